// File: doc/BRIEF.md
# PWM Event Interrupt and Trigger Selector

This block sits beside a PWM counter and turns the counter's single-cycle event strobes into two outputs: a level interrupt that stays asserted until software clears it, and a one-clock trigger pulse for starting an ADC conversion. There are six event strobes. They mark the counter reaching zero, the counter reaching its load value, comparator A matching while counting up, comparator A matching while counting down, and the same two cases for comparator B.

Each output has its own 6-bit enable mask. The two masks are independent, so the interrupt and the trigger can follow the same events or different ones. The interrupt side keeps a sticky status vector of enabled events, and its output is the OR of that vector. A second sticky vector records every event whatever the masks say. Both vectors are cleared by one shared write-one-to-clear strobe input. The outputs follow the raw counter events. Any edge delay added later in the PWM path plays no part.

Top module: `pwm_evt_selector`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `irq_sts`, `raw_sts`, `irq_out` and `trig_out` are all zero.
- R2: Event bit positions are: bit 0 counter zero, bit 1 counter at load, bit 2 A match up, bit 3 A match down, bit 4 B match up, bit 5 B match down. An event on bit i with `irq_mask[i]`=1 sets `irq_sts[i]` after the next rising clock edge.
- R3: An event whose `irq_mask` bit is 0 leaves its `irq_sts` bit and `irq_out` unchanged.
- R4: `irq_out` is 1 exactly when at least one `irq_sts` bit is 1.
- R5: A set `irq_sts` or `raw_sts` bit holds until a cycle with its `irq_clr` bit at 1, after which it reads 0. `irq_clr` bits at 0 have no effect.
- R6: If an event arrives on bit i in the same cycle as `irq_clr[i]`, the event wins and the bit reads 1 after the edge.
- R7: `trig_out` is 1 for the single cycle after each cycle in which `evt_in & trig_mask` is non-zero, and 0 otherwise. Events in consecutive cycles give a continuous high.
- R8: `trig_mask` and `irq_mask` act independently: an event enabled only for the trigger produces a pulse and sets no `irq_sts` bit.
- R9: `raw_sts[i]` is set by every event on bit i, whatever either mask holds.
- R10: Clearing `irq_mask` bits does not clear `irq_sts` bits that are already latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_in | input | 6 | Single-cycle counter event strobes, bit order as in R2 |
| irq_mask | input | 6 | Events enabled for the interrupt |
| trig_mask | input | 6 | Events enabled for the trigger |
| irq_clr | input | 6 | Write-one-to-clear strobe for both status vectors |
| irq_sts | output | 6 | Sticky status of enabled events |
| raw_sts | output | 6 | Sticky status of all events |
| irq_out | output | 1 | Level interrupt |
| trig_out | output | 1 | One-cycle ADC trigger pulse |

## Verification
The bench builds the block with the default event width of six, so every position in the bit map is driven. This covers the full and disjoint mask patterns, such as alternating interrupt and trigger masks. It also covers all-ones clears against a full status vector. At this width each event can be steered on its own, so each one can be checked to set only its own status bit. The bench also covers the collision of an event with its own clear, and back-to-back trigger events.

// File: rtl/pwm_evsel_pkg.sv
package pwm_evsel_pkg;
  localparam int unsigned EVT_COUNT = 6;

  typedef enum int unsigned {
    EV_ZERO   = 0,
    EV_LOAD   = 1,
    EV_A_UP   = 2,
    EV_A_DOWN = 3,
    EV_B_UP   = 4,
    EV_B_DOWN = 5
  } evt_idx_e;
endpackage

// File: rtl/pwm_evsel_sticky.sv
module pwm_evsel_sticky #(
  parameter int unsigned EVT_W = pwm_evsel_pkg::EVT_COUNT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] evt,
  input  logic [EVT_W-1:0] mask,
  input  logic [EVT_W-1:0] clr,
  output logic [EVT_W-1:0] sts
);
  logic live;

  always_ff @(posedge clk) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  for (genvar i = 0; i < EVT_W; i++) begin : g_bit
    // set has priority over clear so a colliding event is never lost
    always_ff @(posedge clk) begin
      if (!rst_n)                   sts[i] <= 1'b0;
      else if (evt[i] && mask[i])   sts[i] <= 1'b1;
      else if (clr[i])              sts[i] <= 1'b0;
    end

    // R2
    sts_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      live && $past(evt[i] && mask[i] && rst_n) |-> sts[i]);
    // R5
    sts_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      live && $past(clr[i] && !(evt[i] && mask[i])) |-> !sts[i]);
    // R3
    sts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      live && $past(!clr[i] && !(evt[i] && mask[i])) |-> sts[i] == $past(sts[i]));
  end
endmodule

// File: rtl/pwm_evsel_trig.sv
module pwm_evsel_trig #(
  parameter int unsigned EVT_W = pwm_evsel_pkg::EVT_COUNT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] evt,
  input  logic [EVT_W-1:0] mask,
  output logic             trig
);
  logic             live;
  logic [EVT_W-1:0] hit;

  assign hit = evt & mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live <= 1'b0;
      trig <= 1'b0;
    end else begin
      live <= 1'b1;
      trig <= |hit;
    end
  end

  // R7
  trig_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live && $past(|(evt & mask)) |-> trig);
  // R7
  trig_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live && $past((evt & mask) == '0) |-> !trig);
endmodule

// File: rtl/pwm_evt_selector.sv
module pwm_evt_selector #(
  parameter int unsigned EVT_W = pwm_evsel_pkg::EVT_COUNT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] evt_in,
  input  logic [EVT_W-1:0] irq_mask,
  input  logic [EVT_W-1:0] trig_mask,
  input  logic [EVT_W-1:0] irq_clr,
  output logic [EVT_W-1:0] irq_sts,
  output logic [EVT_W-1:0] raw_sts,
  output logic             irq_out,
  output logic             trig_out
);
  localparam logic [EVT_W-1:0] ALL_ON = {EVT_W{1'b1}};

  pwm_evsel_sticky #(.EVT_W(EVT_W)) i_irq_sts (
    .clk  (clk),
    .rst_n(rst_n),
    .evt  (evt_in),
    .mask (irq_mask),
    .clr  (irq_clr),
    .sts  (irq_sts)
  );

  pwm_evsel_sticky #(.EVT_W(EVT_W)) i_raw_sts (
    .clk  (clk),
    .rst_n(rst_n),
    .evt  (evt_in),
    .mask (ALL_ON),
    .clr  (irq_clr),
    .sts  (raw_sts)
  );

  pwm_evsel_trig #(.EVT_W(EVT_W)) i_trig (
    .clk  (clk),
    .rst_n(rst_n),
    .evt  (evt_in),
    .mask (trig_mask),
    .trig (trig_out)
  );

  assign irq_out = |irq_sts;

  // R9
  raw_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_sts & ~raw_sts) == '0 || $past(irq_clr == '0));
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> !irq_out && !trig_out && raw_sts == '0);
endmodule

// File: tb/test_pwm_evt_selector.sv
module test_pwm_evt_selector;
  localparam int W = 6;
  localparam int NV = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] evt_in = '0, irq_mask = '0, trig_mask = '0, irq_clr = '0;
  logic [W-1:0] irq_sts, raw_sts;
  logic irq_out, trig_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwm_evt_selector #(.EVT_W(W)) i_pwm_evt_selector (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .irq_mask(irq_mask),
    .trig_mask(trig_mask), .irq_clr(irq_clr), .irq_sts(irq_sts),
    .raw_sts(raw_sts), .irq_out(irq_out), .trig_out(trig_out)
  );

  // {evt, irq_mask, trig_mask, clr, exp_sts, exp_raw, exp_irq, exp_trig}
  localparam logic [37:0] VEC [NV] = '{
    {6'h01, 6'h01, 6'h00, 6'h00, 6'h01, 6'h01, 1'b1, 1'b0}, // R2 zero event
    {6'h00, 6'h01, 6'h00, 6'h00, 6'h01, 6'h01, 1'b1, 1'b0}, // R5 hold
    {6'h02, 6'h01, 6'h02, 6'h00, 6'h01, 6'h03, 1'b1, 1'b1}, // R3 R8 R9
    {6'h00, 6'h01, 6'h02, 6'h02, 6'h01, 6'h01, 1'b1, 1'b0}, // R5 partial clear
    {6'h01, 6'h01, 6'h00, 6'h01, 6'h01, 6'h01, 1'b1, 1'b0}, // R6 collision
    {6'h00, 6'h00, 6'h00, 6'h01, 6'h00, 6'h00, 1'b0, 1'b0}, // R4 R5 cleared
    {6'h3F, 6'h2A, 6'h15, 6'h00, 6'h2A, 6'h3F, 1'b1, 1'b1}, // R8 disjoint masks
    {6'h00, 6'h00, 6'h00, 6'h00, 6'h2A, 6'h3F, 1'b1, 1'b0}, // R10 mask dropped
    {6'h00, 6'h00, 6'h00, 6'h3F, 6'h00, 6'h00, 1'b0, 1'b0}, // R5 full clear
    {6'h20, 6'h00, 6'h20, 6'h00, 6'h00, 6'h20, 1'b0, 1'b1}, // R3 R7
    {6'h10, 6'h00, 6'h10, 6'h00, 6'h00, 6'h30, 1'b0, 1'b1}, // R7 back-to-back
    {6'h00, 6'h00, 6'h3F, 6'h30, 6'h00, 6'h00, 1'b0, 1'b0}  // R7 R9 end
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [W-1:0] e, input logic [W-1:0] im,
                      input logic [W-1:0] tm, input logic [W-1:0] c);
    evt_in = e; irq_mask = im; trig_mask = tm; irq_clr = c;
    @(negedge clk);
    evt_in = '0; irq_clr = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 sts in reset", {26'd0, irq_sts}, 32'd0);
    chk("R1 irq/trig in reset", {30'd0, irq_out, trig_out}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 raw after reset", {26'd0, raw_sts}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      logic [37:0] r;
      r = VEC[v];
      step(r[37:32], r[31:26], r[25:20], r[19:14]);
      chk($sformatf("table row %0d irq_sts (R2 R3 R5 R6 R10)", v), {26'd0, irq_sts}, {26'd0, r[13:8]});
      chk($sformatf("table row %0d raw_sts (R9)", v), {26'd0, raw_sts}, {26'd0, r[7:2]});
      chk($sformatf("table row %0d irq_out (R4)", v), {31'd0, irq_out}, {31'd0, r[1]});
      chk($sformatf("table row %0d trig_out (R7 R8)", v), {31'd0, trig_out}, {31'd0, r[0]});
    end

    // R2: each event position sets only its own bit
    for (int b = 0; b < W; b++) begin
      step(6'(1 << b), 6'h3F, 6'h00, 6'h00);
      chk($sformatf("R2 bit %0d", b), {26'd0, irq_sts}, {26'd0, 6'(1 << b)});
      step(6'h00, 6'h3F, 6'h00, 6'h3F);
    end

    // R7: isolated event gives exactly one high cycle
    step(6'h04, 6'h00, 6'h04, 6'h00);
    chk("R7 pulse high", {31'd0, trig_out}, 32'd1);
    @(negedge clk);
    chk("R7 pulse ends", {31'd0, trig_out}, 32'd0);

    // R3: masked-off event leaves irq low
    step(6'h08, 6'h37, 6'h00, 6'h00);
    chk("R3 masked off", {31'd0, irq_out}, 32'd0);

    // R1: reset mid-run clears latched state
    step(6'h3F, 6'h3F, 6'h00, 6'h00);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset clears sts", {20'd0, irq_sts, raw_sts}, 32'd0);
    rst_n = 1'b1;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual timeout expected completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule